// File: doc/BRIEF.md
# SD Card SPI Command Framer

This block issues one command to a memory card running in SPI mode and returns the card's one-byte reply. It sits above a byte-exchange SPI master. Each exchange moves one byte out and brings one byte back, using a request strobe and an acknowledge strobe. The block also owns the card's chip-select line.

A caller supplies a 6-bit command index, a 32-bit argument and a flag that marks an application-specific command, then pulses the start input. The block handles the rest of the command exchange:
- it toggles chip select around a filler byte;
- it waits for the card to stop signalling busy;
- for application commands, it first sends the prefix command 55;
- it sends the six-byte frame with the right check byte;
- it polls for the reply.

When the reply is in, it pulses done and holds the reply and a timeout flag until the next start. Chip select stays low after a normal finish, so a data phase or a trailer read can follow in the same transaction.

Millisecond timing comes from a single-cycle tick input, and both bounds are parameters.

Top module: `sd_cmd_framer`

## Requirements
- R1: The first frame byte is 0x40 ORed with the 6-bit command index. The 32-bit argument follows in the next four bytes, most significant byte first.
- R2: The sixth frame byte is 0x95 for index 0, 0x87 for index 8, and 0x01 for every other index.
- R3: Every frame starts with two 0xFF filler exchanges. The first is sent with chip select high (card_cs_n = 1). The second is sent with chip select low (card_cs_n = 0).
- R4: After the second filler, the block sends 0xFF exchanges with chip select low until the card returns 0xFF. The frame starts only after that 0xFF.
- R5: The ready wait is bounded. After the wait has run READY_MS ticks of ms_tick, the next non-0xFF byte from the card ends the command: chip select goes high, the reply is 0xFF, cmd_timeout is 1, and no frame is sent. The next command works normally.
- R6: For index 12, one extra 0xFF exchange follows the frame. Its returned byte is discarded before reply polling starts.
- R7: Reply polling sends at most POLL_LIMIT 0xFF exchanges. It stops at the first returned byte whose bit 7 is 0. The reply is the last byte received, even if its bit 7 is 1.
- R8: When cmd_app is 1, the block first runs a full command with index 55 and argument 0. If that reply is greater than 1, the block finishes with it and sends no main command. Otherwise it runs the requested command.
- R9: cmd_done is high for exactly one cycle per command. After a command that did not time out, chip select stays low.
- R10: After reset, card_cs_n is 1, and xfer_req and cmd_done are 0.
- R11: xfer_req is a one-cycle pulse. No new request is raised until the current one has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| cmd_start | input | 1 | Starts a command; sampled while idle |
| cmd_app | input | 1 | Marks an application command; the index-55 prefix is sent first |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_done | output | 1 | One-cycle pulse when the command ends |
| cmd_resp | output | 8 | Reply byte, held from done until the next start |
| cmd_timeout | output | 1 | Ready-wait timeout flag, held with cmd_resp |
| card_cs_n | output | 1 | Card chip select, active low |
| xfer_req | output | 1 | Byte exchange request pulse |
| xfer_tx | output | 8 | Byte to send, valid with xfer_req |
| xfer_ack | input | 1 | Exchange finished; xfer_rx is valid |
| xfer_rx | input | 8 | Byte received from the card |

## Verification
The properties assume the SPI master acknowledges each request exactly once, some cycles after it, and never acknowledges without an outstanding request. The properties also assume that cmd_start comes only while the block is idle. The bench's card model keeps to both rules. It answers each request on the second falling edge after the request and raises the acknowledge for a single cycle. The driver pulses start only after the previous done has been seen.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [5:0] IDX_RESET   = 6'd0;
    localparam logic [5:0] IDX_IFCOND  = 6'd8;
    localparam logic [5:0] IDX_STOP    = 6'd12;
    localparam logic [5:0] IDX_APP     = 6'd55;
    localparam logic [7:0] CRC_RESET   = 8'h95;
    localparam logic [7:0] CRC_IFCOND  = 8'h87;
    localparam logic [7:0] CRC_DUMMY   = 8'h01;
    localparam int         FRAME_BYTES = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESEL,
        ST_SEL,
        ST_READY,
        ST_FRAME,
        ST_STUFF,
        ST_POLL
    } fr_state_e;

endpackage

// File: rtl/sd_frame_byte.sv
module sd_frame_byte
    import sd_cmd_pkg::*;
(
    input  logic [5:0]  idx,
    input  logic [31:0] arg,
    input  logic [2:0]  pos,
    output logic [7:0]  frame_byte
);
    logic [7:0] crc;

    always_comb begin
        if (idx == IDX_RESET)       crc = CRC_RESET;
        else if (idx == IDX_IFCOND) crc = CRC_IFCOND;
        else                        crc = CRC_DUMMY;
    end

    always_comb begin
        case (pos)
            3'd0:    frame_byte = {2'b01, idx};
            3'd1:    frame_byte = arg[31:24];
            3'd2:    frame_byte = arg[23:16];
            3'd3:    frame_byte = arg[15:8];
            3'd4:    frame_byte = arg[7:0];
            default: frame_byte = crc;
        endcase
    end
endmodule

// File: rtl/sd_ms_window.sv
module sd_ms_window #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (tick && !expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= CW'(LIMIT));
endmodule

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer
    import sd_cmd_pkg::*;
#(
    parameter int READY_MS   = 500,
    parameter int POLL_LIMIT = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ms_tick,
    input  logic        cmd_start,
    input  logic        cmd_app,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    output logic        cmd_done,
    output logic [7:0]  cmd_resp,
    output logic        cmd_timeout,
    output logic        card_cs_n,
    output logic        xfer_req,
    output logic [7:0]  xfer_tx,
    input  logic        xfer_ack,
    input  logic [7:0]  xfer_rx
);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam logic [2:0] LAST_POS = 3'(FRAME_BYTES - 1);

    typedef struct packed {
        fr_state_e   state;
        logic        pend;
        logic        cs_n;
        logic [2:0]  pos;
        logic [PW-1:0] poll;
        logic [5:0]  cur_idx;
        logic [31:0] cur_arg;
        logic [5:0]  main_idx;
        logic [31:0] main_arg;
        logic        prefix;
        logic [7:0]  resp;
        logic        tmo;
        logic        done;
    } fr_regs_t;

    fr_regs_t q, d;
    logic [7:0] frame_byte;
    logic       wait_expired;
    logic       got;

    sd_frame_byte u_frame (
        .idx        (q.cur_idx),
        .arg        (q.cur_arg),
        .pos        (q.pos),
        .frame_byte (frame_byte)
    );

    sd_ms_window #(.LIMIT(READY_MS)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (q.state != ST_READY),
        .tick    (ms_tick),
        .expired (wait_expired)
    );

    assign got = q.pend && xfer_ack;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        xfer_req = 1'b0;
        xfer_tx  = (q.state == ST_FRAME) ? frame_byte : FILL_BYTE;

        if (q.state != ST_IDLE && !q.pend) begin
            xfer_req = 1'b1;
            d.pend   = 1'b1;
        end
        if (got) d.pend = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (cmd_start) begin
                    d.main_idx = cmd_index;
                    d.main_arg = cmd_arg;
                    d.prefix   = cmd_app;
                    d.cur_idx  = cmd_app ? IDX_APP : cmd_index;
                    d.cur_arg  = cmd_app ? 32'd0 : cmd_arg;
                    d.tmo      = 1'b0;
                    d.cs_n     = 1'b1;
                    d.state    = ST_DESEL;
                end
            end
            ST_DESEL: begin
                if (got) begin
                    d.cs_n  = 1'b0;
                    d.state = ST_SEL;
                end
            end
            ST_SEL: begin
                if (got) d.state = ST_READY;
            end
            ST_READY: begin
                if (got) begin
                    if (xfer_rx == FILL_BYTE) begin
                        d.pos   = '0;
                        d.state = ST_FRAME;
                    end else if (wait_expired) begin
                        d.cs_n  = 1'b1;
                        d.resp  = FILL_BYTE;
                        d.tmo   = 1'b1;
                        d.done  = 1'b1;
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_FRAME: begin
                if (got) begin
                    if (q.pos == LAST_POS) begin
                        d.poll  = '0;
                        d.state = (q.cur_idx == IDX_STOP) ? ST_STUFF : ST_POLL;
                    end else begin
                        d.pos = q.pos + 3'd1;
                    end
                end
            end
            ST_STUFF: begin
                if (got) d.state = ST_POLL;
            end
            ST_POLL: begin
                if (got) begin
                    if (!xfer_rx[7] || q.poll == PW'(POLL_LIMIT - 1)) begin
                        if (q.prefix && xfer_rx <= 8'd1) begin
                            d.prefix  = 1'b0;
                            d.cur_idx = q.main_idx;
                            d.cur_arg = q.main_arg;
                            d.cs_n    = 1'b1;
                            d.state   = ST_DESEL;
                        end else begin
                            d.resp  = xfer_rx;
                            d.done  = 1'b1;
                            d.state = ST_IDLE;
                        end
                    end else begin
                        d.poll = q.poll + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cs_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cmd_done    = q.done;
    assign cmd_resp    = q.resp;
    assign cmd_timeout = q.tmo;
    assign card_cs_n   = q.cs_n;
endmodule

// File: rtl/sd_cmd_framer_chk.sv
module sd_cmd_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_done,
    input logic [7:0] cmd_resp,
    input logic       cmd_timeout,
    input logic       card_cs_n,
    input logic       xfer_req,
    input logic [7:0] xfer_tx
);
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done); // R9

    AST_TIMEOUT_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd_timeout) |-> (cmd_resp == 8'hFF && card_cs_n)); // R5

    AST_STAYS_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !cmd_timeout) |-> !card_cs_n); // R9

    AST_FRAME_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_tx != 8'hFF) |-> !card_cs_n); // R1
endmodule

bind sd_cmd_framer sd_cmd_framer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_done    (cmd_done),
    .cmd_resp    (cmd_resp),
    .cmd_timeout (cmd_timeout),
    .card_cs_n   (card_cs_n),
    .xfer_req    (xfer_req),
    .xfer_tx     (xfer_tx)
);

// File: tb/sd_cmd_framer_tb_top.sv
module sd_cmd_framer_tb_top;
    localparam int READY_MS   = 3;
    localparam int POLL_LIMIT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_app = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        cmd_done;
    logic [7:0]  cmd_resp;
    logic        cmd_timeout;
    logic        card_cs_n;
    logic        xfer_req;
    logic [7:0]  xfer_tx;
    logic        xfer_ack = 1'b0;
    logic [7:0]  xfer_rx = 8'hFF;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    logic tick_en = 1'b0;
    logic [7:0] rx_default = 8'hFF;

    typedef struct {
        logic       cs;
        logic [7:0] b;
        string      tag;
    } exp_byte_t;

    typedef struct {
        logic [7:0] resp;
        logic       tmo;
        logic       cs;
        string      tag;
    } exp_res_t;

    exp_byte_t  exp_q[$];
    exp_res_t   res_q[$];
    logic [7:0] card_q[$];

    always #5 clk = ~clk;

    sd_cmd_framer #(.READY_MS(READY_MS), .POLL_LIMIT(POLL_LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .cmd_start(cmd_start), .cmd_app(cmd_app), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .cmd_done(cmd_done), .cmd_resp(cmd_resp), .cmd_timeout(cmd_timeout),
        .card_cs_n(card_cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // millisecond tick source
    initial begin
        forever begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                ms_tick = tick_en && (i == 0);
            end
        end
    end

    // card model: answers each request on the second falling edge
    initial begin
        logic       owe;
        logic [7:0] nxt;
        owe = 1'b0;
        nxt = 8'hFF;
        forever begin
            @(negedge clk);
            xfer_ack = 1'b0;
            if (owe) begin
                xfer_ack = 1'b1;
                xfer_rx  = nxt;
                owe      = 1'b0;
            end else if (xfer_req) begin
                if (exp_q.size() > 0) begin
                    exp_byte_t e;
                    e = exp_q.pop_front();
                    check(xfer_tx == e.b, e.tag, "tx byte", 32'(xfer_tx), 32'(e.b));
                    check(card_cs_n == e.cs, e.tag, "cs_n", 32'(card_cs_n), 32'(e.cs));
                end else begin
                    check(xfer_tx == 8'hFF && !card_cs_n, "R5", "wait byte",
                          {23'd0, card_cs_n, xfer_tx}, 32'h0FF);
                end
                nxt = (card_q.size() > 0) ? card_q.pop_front() : rx_default;
                owe = 1'b1;
            end
        end
    end

    // monitor: compares each finished command with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_done) begin
                exp_res_t r;
                if (res_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
                end else begin
                    r = res_q.pop_front();
                    check(cmd_resp == r.resp, r.tag, "reply", 32'(cmd_resp), 32'(r.resp));
                    check(cmd_timeout == r.tmo, r.tag, "timeout flag", 32'(cmd_timeout), 32'(r.tmo));
                    check(card_cs_n == r.cs, "R9", "cs_n at done", 32'(card_cs_n), 32'(r.cs));
                    check(exp_q.size() == 0, r.tag, "bytes left unsent", 32'(exp_q.size()), 32'd0);
                end
                @(negedge clk);
                check(!cmd_done, "R9", "done width", 32'(cmd_done), 32'd0);
                done_cnt++;
            end
        end
    end

    task automatic expb(input logic cs, input logic [7:0] b, input string tag);
        exp_byte_t e;
        e.cs = cs; e.b = b; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // filler pair, ready wait, frame, and the stuff byte for index 12
    task automatic seg_head(input logic [5:0] idx, input logic [31:0] arg, input int busy);
        logic [7:0] crc;
        expb(1'b1, 8'hFF, "R3"); card_q.push_back(8'hFF);
        expb(1'b0, 8'hFF, "R3"); card_q.push_back(8'hFF);
        for (int i = 0; i < busy; i++) begin
            expb(1'b0, 8'hFF, "R4"); card_q.push_back(8'h00);
        end
        expb(1'b0, 8'hFF, "R4"); card_q.push_back(8'hFF);
        crc = (idx == 6'd0) ? 8'h95 : (idx == 6'd8) ? 8'h87 : 8'h01;
        expb(1'b0, {2'b01, idx}, "R1"); card_q.push_back(8'hFF);
        for (int i = 3; i >= 0; i--) begin
            expb(1'b0, arg[i*8 +: 8], "R1"); card_q.push_back(8'hFF);
        end
        expb(1'b0, crc, "R2"); card_q.push_back(8'hFF);
        if (idx == 6'd12) begin
            expb(1'b0, 8'hFF, "R6"); card_q.push_back(8'h00);
        end
    endtask

    task automatic poll(input logic [7:0] b);
        expb(1'b0, 8'hFF, "R7"); card_q.push_back(b);
    endtask

    task automatic expect_res(input logic [7:0] resp, input logic tmo, input logic cs, input string tag);
        exp_res_t r;
        r.resp = resp; r.tmo = tmo; r.cs = cs; r.tag = tag;
        res_q.push_back(r);
    endtask

    task automatic run(input logic [5:0] idx, input logic app, input logic [31:0] arg);
        int prev;
        prev = done_cnt;
        @(negedge clk);
        cmd_index = idx; cmd_app = app; cmd_arg = arg; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (done_cnt == prev) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(card_cs_n == 1'b1, "R10", "cs_n after reset", 32'(card_cs_n), 32'd1);
        check(!xfer_req, "R10", "req after reset", 32'(xfer_req), 32'd0);
        check(!cmd_done, "R10", "done after reset", 32'(cmd_done), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!xfer_req && card_cs_n, "R11", "no request while idle", 32'(xfer_req), 32'd0);

        // index 0, immediate ready, reply on second poll
        seg_head(6'd0, 32'd0, 0); poll(8'hFF); poll(8'h01);
        expect_res(8'h01, 1'b0, 1'b0, "R7");
        run(6'd0, 1'b0, 32'd0);

        // index 8, two busy bytes first
        seg_head(6'd8, 32'h0000_01AA, 2); poll(8'h01);
        expect_res(8'h01, 1'b0, 1'b0, "R4");
        run(6'd8, 1'b0, 32'h0000_01AA);

        // index 17, reply never has bit 7 clear: limit reached
        seg_head(6'd17, 32'h1234_5678, 0);
        for (int i = 0; i < POLL_LIMIT - 1; i++) poll(8'hFF);
        poll(8'hC1);
        expect_res(8'hC1, 1'b0, 1'b0, "R7");
        run(6'd17, 1'b0, 32'h1234_5678);

        // index 12: stuff byte returns 0x00 and must be skipped
        seg_head(6'd12, 32'd0, 1); poll(8'h7F);
        expect_res(8'h7F, 1'b0, 1'b0, "R6");
        run(6'd12, 1'b0, 32'd0);

        // application command, prefix accepted
        seg_head(6'd55, 32'd0, 0); poll(8'h01);
        seg_head(6'd41, 32'h4000_0000, 0); poll(8'hFF); poll(8'h00);
        expect_res(8'h00, 1'b0, 1'b0, "R8");
        run(6'd41, 1'b1, 32'h4000_0000);

        // application command, prefix rejected: main frame not sent
        seg_head(6'd55, 32'd0, 1); poll(8'h05);
        expect_res(8'h05, 1'b0, 1'b0, "R8");
        run(6'd23, 1'b1, 32'h0000_0005);

        // ready wait never ends
        expb(1'b1, 8'hFF, "R3"); card_q.push_back(8'hFF);
        expb(1'b0, 8'hFF, "R3"); card_q.push_back(8'hFF);
        rx_default = 8'h00;
        tick_en = 1'b1;
        expect_res(8'hFF, 1'b1, 1'b1, "R5");
        run(6'd17, 1'b0, 32'h0000_0200);
        tick_en = 1'b0;
        rx_default = 8'hFF;
        check(card_cs_n == 1'b1, "R5", "cs_n after timeout", 32'(card_cs_n), 32'd1);

        // recovery after a timeout
        seg_head(6'd24, 32'h0000_00A5, 0); poll(8'h00);
        expect_res(8'h00, 1'b0, 1'b0, "R5");
        run(6'd24, 1'b0, 32'h0000_00A5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule